// File: doc/BRIEF.md
# Parity-Protected Microinstruction Store

This block is the control store of a microcoded engine. It holds 4096 microinstructions of 34 bits each. Every word is treated as two 17-bit halves, and each half carries its own parity bit. The low half holds the register-stack, ALU-function, B-select, load-control and A-select fields. The high half holds the block, function and jump-control fields.

A write carries an address, the instruction and two per-half "corrupt" requests. The parity bit stored for a half is its true odd parity inverted wherever the matching request bit is set. Software uses this to plant words that read back with deliberate parity errors. A word with both halves corrupted serves as a breakpoint marker.

A read returns the word one clock later, together with a valid strobe, a per-half parity-error flag and a breakpoint output. The breakpoint output is high when both halves fail their check. Reset clears only the output strobe and leaves the array untouched. An array word that has never been written holds no valid parity until it is written once.

Top module: `ucode_store`

## Requirements
- R1: A word written to any address from 0 to 4095 reads back unchanged on all 34 bits of `rd_data`.
- R2: Parity is checked per half. Bits 16:0 form half 0, reported on `rd_perr[0]`. Bits 33:17 form half 1, reported on `rd_perr[1]`. An error in one half never raises the other half's flag.
- R3: Odd parity is used. `rd_perr[k]` on a read equals the `wr_bad[k]` value given with the last write to that address.
- R4: `rd_brk` is high exactly when both `rd_perr` bits are high.
- R5: A read requested with `rd_en` in one cycle makes `rd_valid` high in the next cycle, with the data and flags present in that same cycle. With no request, `rd_valid` is low in the next cycle.
- R6: While `rd_valid` is low, `rd_perr` is 2'b00 and `rd_brk` is low.
- R7: A read and a write to the same address in the same cycle return the contents held before the write. The new word is returned by later reads.
- R8: An active-low reset forces `rd_valid` low and leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 12 | Write address |
| wr_data | input | 34 | Microinstruction to store |
| wr_bad | input | 2 | Per-half parity corruption request (bit 0 low half, bit 1 high half) |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Read address |
| rd_data | output | 34 | Microinstruction read |
| rd_valid | output | 1 | Read result valid |
| rd_perr | output | 2 | Per-half parity error flags |
| rd_brk | output | 1 | Both halves failed (breakpoint marker) |

## Verification
A corrupted stored word or parity bit shows up on the very next read of that address. It appears either as a `rd_data` mismatch or as a flag that no longer mirrors the injected `wr_bad` bits. A wrong read-port register shows within one cycle as a `rd_valid` strobe out of step with `rd_en`, or as flags leaking while the strobe is low.

The cycle-level model keeps the written data and injection bits per address. It predicts old-data returns for colliding accesses. Every read is compared against the model, including reads after a reset.

// File: rtl/ucode_store.sv
module ucode_store #(
  parameter int ADDR_W = 12,
  parameter int HALF_W = 17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [2*HALF_W-1:0]   wr_data,
  input  logic [1:0]            wr_bad,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [2*HALF_W-1:0]   rd_data,
  output logic                  rd_valid,
  output logic [1:0]            rd_perr,
  output logic                  rd_brk
);
  localparam int WORD_W  = 2 * HALF_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int STORE_W = WORD_W + 2;

  logic [STORE_W-1:0] mem [DEPTH];
  logic [STORE_W-1:0] q;
  logic [1:0]         wr_par;
  logic [1:0]         err;

  assign wr_par[0] = ~(^wr_data[HALF_W-1:0]) ^ wr_bad[0];
  assign wr_par[1] = ~(^wr_data[WORD_W-1:HALF_W]) ^ wr_bad[1];

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= {wr_par, wr_data};

  always_ff @(posedge clk)
    if (rd_en) q <= mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;

  assign err[0] = ~(^{q[WORD_W],   q[HALF_W-1:0]});
  assign err[1] = ~(^{q[WORD_W+1], q[WORD_W-1:HALF_W]});

  assign rd_data = q[WORD_W-1:0];
  assign rd_perr = rd_valid ? err : 2'b00;
  assign rd_brk  = &rd_perr;
endmodule

module ucode_store_chk #(
  parameter int ADDR_W = 12,
  parameter int HALF_W = 17
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [2*HALF_W-1:0]   wr_data,
  input logic [1:0]            wr_bad,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     rd_addr,
  input logic [2*HALF_W-1:0]   rd_data,
  input logic                  rd_valid,
  input logic [1:0]            rd_perr,
  input logic                  rd_brk
);
  p_valid_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_no_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  p_flags_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_perr == 2'b00 && !rd_brk));

  p_brk_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_brk == (rd_perr == 2'b11));

  p_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(wr_en) && $past(wr_addr) == rd_addr &&
     !(wr_en && wr_addr == rd_addr))
    |=> (rd_data == $past(wr_data, 2) && rd_perr == $past(wr_bad, 2)));
endmodule

bind ucode_store ucode_store_chk #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_chk (.*);

// File: tb/sim_ucode_store.sv
module sim_ucode_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [33:0] wr_data = '0;
  logic [1:0]  wr_bad = '0;
  logic [33:0] rd_data;
  logic        rd_valid, rd_brk;
  logic [1:0]  rd_perr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [35:0] mdl [int];

  always #10 clk = ~clk;

  ucode_store u0 (.*);

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [11:0] wa,
                      input logic [33:0] wd, input logic [1:0] wb,
                      input logic re, input logic [11:0] ra);
    logic [35:0] old;
    wr_en = we; wr_addr = wa; wr_data = wd; wr_bad = wb;
    rd_en = re; rd_addr = ra;
    old = mdl.exists(int'(ra)) ? mdl[int'(ra)] : '0;
    if (we) mdl[int'(wa)] = {wb, wd};
    @(negedge clk);
    chk(tag, "rd_valid", 64'(rd_valid), 64'(re));
    if (re) begin
      chk(tag, "rd_data", 64'(rd_data), 64'(old[33:0]));
      chk(tag, "rd_perr", 64'(rd_perr), 64'(old[35:34]));
      chk(tag, "rd_brk",  64'(rd_brk),  64'(&old[35:34]));
    end else begin
      chk(tag, "rd_perr idle", 64'(rd_perr), 64'd0);
      chk(tag, "rd_brk idle",  64'(rd_brk),  64'd0);
    end
  endtask

  function automatic logic [11:0] adr(input int i);
    return 12'((i * 97 + 5) & 12'hFFF);
  endfunction

  function automatic logic [33:0] rnd();
    return 34'({$urandom(), $urandom()});
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "rd_valid in reset", 64'(rd_valid), 64'd0);
    rst_n = 1'b1;
    step("R6", 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 40; i++)
      step("R3", 1, adr(i), rnd(), 2'(i % 4), 0, 0);
    for (int i = 0; i < 40; i++)
      step("R4", 1, adr(i + 40), rnd(), 2'(i % 4), 1, adr(i));
    for (int i = 40; i < 80; i++)
      step("R3", 0, 0, 0, 0, 1, adr(i));

    step("R1", 1, 12'd0, 34'h3_FFFF_FFFF, 2'b00, 0, 0);
    step("R1", 1, 12'hFFF, 34'h2_AAAA_5555, 2'b00, 1, 12'd0);
    step("R1", 0, 0, 0, 0, 1, 12'hFFF);

    step("R2", 1, 12'd7, 34'h0_0001_FFFF, 2'b10, 0, 0);
    step("R2", 1, 12'd8, 34'h3_FFFE_0000, 2'b01, 1, 12'd7);
    step("R2", 1, 12'd9, 34'h0_0001_0000, 2'b00, 1, 12'd8);
    step("R2", 0, 0, 0, 0, 1, 12'd9);

    step("R7", 1, 12'd100, 34'h1_2345_6789, 2'b00, 0, 0);
    step("R7", 1, 12'd100, 34'h0_FEDC_BA98, 2'b11, 1, 12'd100);
    step("R7", 0, 0, 0, 0, 1, 12'd100);
    step("R5", 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0);

    wr_en = 0; rd_en = 0; rst_n = 1'b0;
    @(negedge clk);
    chk("R8", "rd_valid in reset", 64'(rd_valid), 64'd0);
    rst_n = 1'b1;
    step("R8", 0, 0, 0, 0, 1, adr(3));
    step("R8", 0, 0, 0, 0, 1, 12'd100);
    step("R8", 0, 0, 0, 0, 0, 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end
endmodule